// File: doc/BRIEF.md
# Bus-Master Channel Control Registers

This block holds the host-visible control state of one bus-master disk DMA channel: a command byte, a status byte and a 32-bit pointer to the descriptor table in memory. Software reaches it through a 32-bit register port with per-byte write enables. Reads are combinational.

The command byte carries a start bit and a transfer-direction bit. A write only acts when it changes the start bit. On a rising start, the block copies the table base into the current descriptor pointer. If the channel is idle, it also marks the channel active and sends a one-cycle kick to the DMA engine. On a falling start, it sends a one-cycle cancel and drops the active flag.

The status byte combines four kinds of bits:
- an active bit owned by hardware;
- an error bit and an interrupt bit, cleared by writing 1;
- two plain read/write bits.

The drive interrupt level passes straight through to the interrupt output. Its rising edge also latches the interrupt status bit.

Top module: `bm_chan_regs`

## Requirements
- R1: Byte offset 0 is the command byte. Only bit 0 (start) and bit 3 (direction) are stored, and all other bits read back as 0. `dma_dir` always equals the stored bit 3.
- R2: A command write whose bit 0 equals the stored start bit produces no `dma_kick` and no `dma_cancel`, and leaves the active bit unchanged.
- R3: A command write that changes start from 1 to 0 pulses `dma_cancel` for exactly the cycle after the write edge, and clears status bit 0 (active) at that edge.
- R4: A command write that changes start from 0 to 1 loads `dma_desc_ptr` from the base register. If status bit 0 was 0, it also sets that bit and pulses `dma_kick` for the cycle after the write edge.
- R5: Byte offset 2 is the status byte. A write there sets status bits 5 and 6 to the written values and leaves bit 0 untouched. Bits 3, 4 and 7 read as 0.
- R6: Status bit 1 (error) is set by `eng_err`, and status bit 2 (interrupt) is set by an interrupt rise. Writing 1 to either bit clears it, and writing 0 leaves it unchanged. A set in the same cycle as a clearing write wins.
- R7: `irq_out` follows `drv_irq` with no delay. A 0-to-1 change of `drv_irq` between two clock edges sets status bit 2 at the second edge. A steady or low level does not change status.
- R8: Byte offsets 4 to 7 hold the base register in little-endian lane order. Each enabled lane takes its byte, disabled lanes keep their value, and bits 1:0 always read 0.
- R9: While `rst_n` is low at a clock edge, command, status, base and `dma_desc_ptr` clear to 0, and `dma_kick` and `dma_cancel` stay low.
- R10: `eng_done` clears status bit 0 at the next edge. If a start-rise write from idle happens in the same cycle, the bit ends set.
- R11: `reg_addr[2]` selects the word (0 for command/status, 1 for base), and `reg_addr[1:0]` are ignored. Read bytes 1 and 3 of word 0 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte address; bit 2 selects the word |
| reg_be | input | 4 | Byte lane write enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word |
| dma_kick | output | 1 | One-cycle start request to the DMA engine |
| dma_cancel | output | 1 | One-cycle abort request to the DMA engine |
| dma_dir | output | 1 | Transfer direction from command bit 3 |
| dma_desc_ptr | output | 32 | Current descriptor pointer |
| eng_done | input | 1 | Engine reports the transfer finished |
| eng_err | input | 1 | Engine reports an error |
| drv_irq | input | 1 | Interrupt level from the drive |
| irq_out | output | 1 | Forwarded interrupt line |

## Verification
Register state, `dma_kick`, `dma_cancel` and `dma_desc_ptr` are due one edge after the write, done, error or interrupt rise that causes them. `reg_rdata`, `dma_dir` and `irq_out` are valid in the same cycle as the address or state they reflect. The bench drives inputs on the falling edge and advances a behavioural model on each rising edge. Just before driving new inputs, it compares every output against the model; this is exactly one edge after the stimulus, so single-cycle pulses are seen in their only valid cycle. Sequences target each priority case, including a clearing write that coincides with a set, and completion coinciding with a start.

// File: rtl/bm_chan_pkg.sv
// Package: shared constants for the bus-master channel registers.
// Assumes a 32-bit register port with four byte lanes.
package bm_chan_pkg;
    localparam int REG_W   = 32;
    localparam int LANES   = REG_W / 8;
    localparam int ADDR_W  = 3;
    // Command byte fields
    localparam int CMD_START = 0;
    localparam int CMD_DIR   = 3;
    localparam logic [7:0] CMD_KEEP = 8'h09;
    // Status byte fields
    localparam int ST_ACT = 0;
    localparam int ST_ERR = 1;
    localparam int ST_INT = 2;
    localparam int ST_SW5 = 5;
    localparam int ST_SW6 = 6;
    // Byte lanes within word 0
    localparam int LANE_CMD  = 0;
    localparam int LANE_STAT = 2;
endpackage

// File: rtl/bm_cmd_reg.sv
// Module: command byte and start/stop edge detection.
// Keeps the start and direction bits. It acts only when a write changes
// the start bit, and registers the kick and cancel pulses for the engine.
// Assumes wr_en is already qualified by word select and lane 0 enable.
module bm_cmd_reg
    import bm_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wbyte,
    input  logic       active_q,
    output logic [7:0] cmd_q,
    output logic       kick_q,
    output logic       cancel_q,
    output logic       set_act,
    output logic       clr_act,
    output logic       reload
);
    logic start_chg;
    logic start_rise;
    logic start_fall;

    // Decode a change of the start bit from the incoming write
    always_comb begin
        start_chg  = wr_en && (wbyte[CMD_START] != cmd_q[CMD_START]);
        start_rise = start_chg && wbyte[CMD_START];
        start_fall = start_chg && !wbyte[CMD_START];
        set_act    = start_rise && !active_q;
        clr_act    = start_fall;
        reload     = start_rise;
    end

    // Store the kept command bits and register the engine pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            kick_q   <= 1'b0;
            cancel_q <= 1'b0;
        end else begin
            if (wr_en) cmd_q <= wbyte & CMD_KEEP;
            kick_q   <= set_act;
            cancel_q <= start_fall;
        end
    end

    AST_SAME_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wbyte[CMD_START] == cmd_q[CMD_START])) |=> (!kick_q && !cancel_q)); // R2
    AST_CANCEL_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_q |-> !cmd_q[CMD_START]); // R3
endmodule

// File: rtl/bm_stat_reg.sv
// Module: status byte.
// Holds the hardware-owned active bit, the write-one-to-clear error and
// interrupt bits, and two plain software bits.
// Assumes hardware sets take priority over a clearing write in the same
// cycle, and that a start from idle takes priority over completion.
module bm_stat_reg
    import bm_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wbyte,
    input  logic       set_act,
    input  logic       clr_act,
    input  logic       eng_done,
    input  logic       eng_err,
    input  logic       drv_irq,
    output logic [7:0] stat_q
);
    logic irq_prev;
    logic irq_rise;
    logic act_q, err_q, int_q, sw5_q, sw6_q;

    // Track the previous interrupt level, independent of reset
    always_ff @(posedge clk) begin
        irq_prev <= drv_irq;
    end

    // Detect a rising interrupt level
    always_comb begin
        irq_rise = drv_irq && !irq_prev;
    end

    // Update the active bit: start from idle sets it, stop or done clears it
    always_ff @(posedge clk) begin
        if (!rst_n)                     act_q <= 1'b0;
        else if (set_act)               act_q <= 1'b1;
        else if (clr_act || eng_done)   act_q <= 1'b0;
    end

    // Update the error bit: engine error sets it, writing 1 clears it
    always_ff @(posedge clk) begin
        if (!rst_n)                          err_q <= 1'b0;
        else if (eng_err)                    err_q <= 1'b1;
        else if (wr_en && wbyte[ST_ERR])     err_q <= 1'b0;
    end

    // Update the interrupt bit: interrupt rise sets it, writing 1 clears it
    always_ff @(posedge clk) begin
        if (!rst_n)                          int_q <= 1'b0;
        else if (irq_rise)                   int_q <= 1'b1;
        else if (wr_en && wbyte[ST_INT])     int_q <= 1'b0;
    end

    // Update the two plain software bits on a status write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw5_q <= 1'b0;
            sw6_q <= 1'b0;
        end else if (wr_en) begin
            sw5_q <= wbyte[ST_SW5];
            sw6_q <= wbyte[ST_SW6];
        end
    end

    // Assemble the status byte
    always_comb begin
        stat_q         = '0;
        stat_q[ST_ACT] = act_q;
        stat_q[ST_ERR] = err_q;
        stat_q[ST_INT] = int_q;
        stat_q[ST_SW5] = sw5_q;
        stat_q[ST_SW6] = sw6_q;
    end

    AST_IRQ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_irq) |=> stat_q[ST_INT]); // R7
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wbyte[ST_INT] && !irq_rise) |=> !stat_q[ST_INT]); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !set_act) |=> !stat_q[ST_ACT]); // R10
    AST_ACT_KEPT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !set_act && !clr_act && !eng_done) |=> (stat_q[ST_ACT] == $past(stat_q[ST_ACT]))); // R5
endmodule

// File: rtl/bm_base_reg.sv
// Module: descriptor table base register and current descriptor pointer.
// Each byte lane is written independently, and the two low address bits
// are held at zero. The pointer copies the base when a start rise occurs.
module bm_base_reg
    import bm_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LANES-1:0] be,
    input  logic [REG_W-1:0] wdata,
    input  logic             reload,
    output logic [REG_W-1:0] base_q,
    output logic [REG_W-1:0] ptr_q
);
    logic [REG_W-1:0] base_raw;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        // Write one byte lane of the base register when enabled
        always_ff @(posedge clk) begin
            if (!rst_n)                base_raw[ln*8 +: 8] <= '0;
            else if (wr_en && be[ln])  base_raw[ln*8 +: 8] <= wdata[ln*8 +: 8];
        end
    end

    // Force dword alignment on the visible base value
    always_comb begin
        base_q = {base_raw[REG_W-1:2], 2'b00};
    end

    // Reload the current descriptor pointer on a start rise
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (reload)  ptr_q <= base_q;
    end

    AST_PTR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (ptr_q == $past(base_q))); // R4
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(ptr_q)); // R2
endmodule

// File: rtl/bm_chan_regs.sv
// Module: top of one bus-master channel register set.
// Decodes the byte-enabled register port into the command, status and
// base blocks, builds the read word, and forwards the drive interrupt.
// Assumes word accesses; reg_addr[1:0] are ignored.
module bm_chan_regs
    import bm_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [LANES-1:0]  reg_be,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              dma_kick,
    output logic              dma_cancel,
    output logic              dma_dir,
    output logic [REG_W-1:0]  dma_desc_ptr,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic              drv_irq,
    output logic              irq_out
);
    logic       word_sel;
    logic       cmd_wr, stat_wr, base_wr;
    logic [7:0] cmd_q, stat_q;
    logic       set_act, clr_act, reload;
    logic [REG_W-1:0] base_q;

    // Decode the word select and per-register write enables
    always_comb begin
        word_sel = reg_addr[2];
        cmd_wr   = reg_wr && !word_sel && reg_be[LANE_CMD];
        stat_wr  = reg_wr && !word_sel && reg_be[LANE_STAT];
        base_wr  = reg_wr && word_sel;
    end

    bm_cmd_reg u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmd_wr),
        .wbyte    (reg_wdata[LANE_CMD*8 +: 8]),
        .active_q (stat_q[ST_ACT]),
        .cmd_q    (cmd_q),
        .kick_q   (dma_kick),
        .cancel_q (dma_cancel),
        .set_act  (set_act),
        .clr_act  (clr_act),
        .reload   (reload)
    );

    bm_stat_reg u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (stat_wr),
        .wbyte    (reg_wdata[LANE_STAT*8 +: 8]),
        .set_act  (set_act),
        .clr_act  (clr_act),
        .eng_done (eng_done),
        .eng_err  (eng_err),
        .drv_irq  (drv_irq),
        .stat_q   (stat_q)
    );

    bm_base_reg u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (base_wr),
        .be     (reg_be),
        .wdata  (reg_wdata),
        .reload (reload),
        .base_q (base_q),
        .ptr_q  (dma_desc_ptr)
    );

    // Build the read word and drive the engine-facing levels
    always_comb begin
        reg_rdata = '0;
        if (word_sel) begin
            reg_rdata = base_q;
        end else begin
            reg_rdata[LANE_CMD*8 +: 8]  = cmd_q;
            reg_rdata[LANE_STAT*8 +: 8] = stat_q;
        end
        dma_dir = cmd_q[CMD_DIR];
        irq_out = drv_irq;
    end

    AST_KICK_MEANS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_kick |-> (stat_q[ST_ACT] && cmd_q[CMD_START])); // R4
    AST_CANCEL_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_cancel |-> !stat_q[ST_ACT]); // R3
    AST_NO_KICK_AND_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_kick && dma_cancel)); // R2
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> (base_q[1:0] == 2'b00)); // R8
endmodule

// File: tb/bm_chan_regs_tb.sv
module bm_chan_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dma_kick, dma_cancel, dma_dir, irq_out;
    logic [31:0] dma_desc_ptr;
    logic        eng_done = 1'b0, eng_err = 1'b0, drv_irq = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "R9";
    bit finished = 0;

    // Reference model state
    bit [7:0]  m_cmd;
    bit        m_act, m_err, m_int, m_s5, m_s6;
    bit [31:0] m_base, m_ptr;
    bit        m_kick, m_cancel, m_prev;

    always #4 clk = ~clk;

    bm_chan_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dma_kick(dma_kick), .dma_cancel(dma_cancel), .dma_dir(dma_dir),
        .dma_desc_ptr(dma_desc_ptr), .eng_done(eng_done), .eng_err(eng_err),
        .drv_irq(drv_irq), .irq_out(irq_out)
    );

    // Behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        bit rise, nstart;
        bit [7:0] sb, cb;
        rise = drv_irq && !m_prev;
        m_prev = drv_irq;
        if (!rst_n) begin
            m_cmd = 0; m_act = 0; m_err = 0; m_int = 0; m_s5 = 0; m_s6 = 0;
            m_base = 0; m_ptr = 0; m_kick = 0; m_cancel = 0;
        end else begin
            m_kick = 0; m_cancel = 0;
            sb = reg_wdata[23:16];
            cb = reg_wdata[7:0];
            if (reg_wr && !reg_addr[2] && reg_be[2]) begin
                m_s5 = sb[5]; m_s6 = sb[6];
                if (sb[1]) m_err = 0;
                if (sb[2]) m_int = 0;
            end
            if (eng_err) m_err = 1;
            if (rise) m_int = 1;
            if (eng_done) m_act = 0;
            if (reg_wr && !reg_addr[2] && reg_be[0]) begin
                nstart = cb[0];
                if (nstart != m_cmd[0]) begin
                    if (!nstart) begin
                        m_cancel = 1; m_act = 0;
                    end else begin
                        m_ptr = m_base;
                        if (!m_act) begin m_act = 1; m_kick = 1; end
                    end
                end
                m_cmd = {4'b0, cb[3], 2'b0, cb[0]};
            end
            if (reg_wr && reg_addr[2]) begin
                for (int i = 0; i < 4; i++)
                    if (reg_be[i]) m_base[i*8 +: 8] = reg_wdata[i*8 +: 8];
                m_base[1:0] = 2'b00;
            end
        end
    end

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s/%s at %0t: actual %h expected %h", phase, tag, $time, act, exp);
        end
    endtask

    // Compare every output against the model
    task automatic check_all();
        logic [31:0] exp_rd;
        exp_rd = reg_addr[2] ? m_base
               : {8'h00, 1'b0, m_s6, m_s5, 2'b00, m_int, m_err, m_act, 8'h00, m_cmd};
        cmp("R11 rdata", reg_rdata, exp_rd);
        cmp("R4 kick", {31'b0, dma_kick}, {31'b0, m_kick});
        cmp("R3 cancel", {31'b0, dma_cancel}, {31'b0, m_cancel});
        cmp("R1 dir", {31'b0, dma_dir}, {31'b0, m_cmd[3]});
        cmp("R4 ptr", dma_desc_ptr, m_ptr);
        cmp("R7 irq_out", {31'b0, irq_out}, {31'b0, drv_irq});
    endtask

    // One clock: check at the falling edge, then drive the next inputs
    task automatic step(bit wr, bit [2:0] a, bit [3:0] be, bit [31:0] d,
                        bit done = 0, bit err = 0);
        @(negedge clk);
        check_all();
        reg_wr = wr; reg_addr = a; reg_be = be; reg_wdata = d;
        eng_done = done; eng_err = err;
    endtask

    task automatic idle(int n, bit [2:0] a = 3'd0);
        for (int i = 0; i < n; i++) step(0, a, 4'h0, 32'h0);
    endtask

    task automatic wcmd(bit [7:0] v, bit done = 0);
        step(1, 3'd0, 4'b0001, {24'h0, v}, done);
    endtask

    task automatic wstat(bit [7:0] v, bit err = 0);
        step(1, 3'd0, 4'b0100, {8'h0, v, 16'h0}, 0, err);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        phase = "R9";
        idle(2); idle(1, 3'd4);
        rst_n = 1'b1;
        idle(2);
        phase = "R8";
        step(1, 3'd4, 4'hF, 32'h1234_5677);
        idle(1, 3'd4);
        step(1, 3'd4, 4'b0010, 32'hFFFF_AB00);
        step(1, 3'd6, 4'b1100, 32'hCAFE_0000);
        idle(1, 3'd5);
        phase = "R1";
        wcmd(8'hF6);
        idle(2);
        phase = "R4";
        wcmd(8'h01);
        idle(2);
        phase = "R2";
        wcmd(8'h09);
        idle(1);
        wcmd(8'hFF);
        idle(1);
        phase = "R10";
        step(0, 3'd0, 4'h0, 32'h0, 1);
        idle(1);
        wcmd(8'h01);
        idle(1);
        phase = "R3";
        wcmd(8'h00);
        idle(1);
        wcmd(8'h08);
        idle(1);
        phase = "R10";
        step(1, 3'd4, 4'hF, 32'h8000_0013);
        wcmd(8'h01, 1);
        idle(2);
        phase = "R5";
        wstat(8'h61);
        idle(1);
        wstat(8'h20);
        idle(1);
        wstat(8'h00);
        idle(1);
        phase = "R6";
        step(0, 3'd0, 4'h0, 32'h0, 0, 1);
        idle(1);
        wstat(8'h00);
        idle(1);
        wstat(8'h02);
        idle(1);
        wstat(8'h02, 1);
        idle(1);
        phase = "R7";
        drv_irq = 1'b1;
        idle(3);
        phase = "R6";
        wstat(8'h04);
        idle(2);
        drv_irq = 1'b0;
        idle(2);
        phase = "R7";
        drv_irq = 1'b1;
        wstat(8'h04);
        idle(1);
        drv_irq = 1'b0;
        wstat(8'h06);
        idle(2);
        phase = "R11";
        idle(1, 3'd1); idle(1, 3'd3); idle(1, 3'd7);
        step(1, 3'd0, 4'b1010, 32'hFFFF_FFFF);
        idle(1);
        phase = "R9";
        wcmd(8'h00); idle(1); wcmd(8'h09); drv_irq = 1'b1; idle(1);
        rst_n = 1'b0;
        idle(2); idle(1, 3'd4);
        rst_n = 1'b1;
        idle(3);
        step(0, 3'd4, 4'h0, 32'h0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule